// File: doc/BRIEF.md
# Instant-Clear Word Memory

This block puts a single-port synchronous RAM behind a bank of per-word "written" flags. The whole memory can then be cleared in one clock cycle. Pulsing the clear input drops every flag at once. The RAM cells keep their old values, but those values can no longer be seen. A later write stores its word and raises the flag for that address. A read returns the stored word only when the flag for its address is set. Otherwise it returns all zeros.

The port is a plain single-address port. The address selects the word that is written when write enable is high, and it also selects the word that is read on every cycle. Read data comes out one cycle later. The flag for the read address is sampled in the same cycle as the RAM word, so the mask lines up with the data. A read sees the state as it was before the clock edge, and a write or clear at that edge affects only the following reads.

Top module: `vcr_ram`

## Requirements
- R1: While reset is active, all flags clear and read data is zero. After reset every address reads as zero.
- R2: One cycle with `clr_i` high (and `we_i` low) clears the flag of every word, whatever the depth.
- R3: A cycle with `we_i` high stores `wdata_i` at `addr_i` and sets that address's flag.
- R4: Read latency is one cycle. `rdata_o` shows the word at the `addr_i` presented one cycle earlier, and it is all zeros when that word's flag was clear.
- R5: When the flag for the read address is set, `rdata_o` equals the last word written there.
- R6: Clear can be repeated on consecutive cycles or at any time. A write in the cycle right after a clear takes effect with no recovery gap.
- R7: When clear and write occur in the same cycle, the written address ends valid with the new data, and every other address ends cleared.
- R8: Words written before a clear stay hidden after it, including when a neighbouring address is written again.
- R9: A read is taken before the edge's update. A read in the same cycle as a write to that address returns the old value (or zero if the flag was clear), and a read in the same cycle as a clear returns the pre-clear value.
- R10: Reading the address written in the previous cycle returns the newly written data.
- R11: `DEPTH` (default 512) and `WIDTH` (default 32) are parameters. The address width is `$clog2(DEPTH)`, and `DEPTH` must be a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears flags and read register |
| clr_i | input | 1 | Logical clear of the whole memory |
| we_i | input | 1 | Write enable |
| addr_i | input | $clog2(DEPTH) | Word address for both write and read |
| wdata_i | input | WIDTH | Write data |
| rdata_o | output | WIDTH | Masked read data, one cycle after the address |

## Verification
The properties assume that `addr_i` is always below `DEPTH` and that all inputs are known and held at zero while reset is active. A power-of-two depth satisfies the first condition automatically. The read-after-write property also assumes the write data from two cycles back is still meaningful, which holds because the stimulus changes inputs only between clock edges. The stimulus uses a 16-word configuration, so every address is always legal. It drives idle, zero inputs throughout reset, and it changes inputs only on the falling edge.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

    typedef enum logic [1:0] {
        VCR_IDLE       = 2'b00,
        VCR_WRITE      = 2'b01,
        VCR_CLEAR      = 2'b10,
        VCR_CLEAR_WRITE = 2'b11
    } vcr_op_e;

    function automatic vcr_op_e vcr_decode(input logic clr, input logic we);
        vcr_op_e op;
        unique case ({clr, we})
            2'b01:   op = VCR_WRITE;
            2'b10:   op = VCR_CLEAR;
            2'b11:   op = VCR_CLEAR_WRITE;
            default: op = VCR_IDLE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/vcr_flag_array.sv
module vcr_flag_array #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    output logic          hit_o
);
    import vcr_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0] vld;
    } flag_st_t;

    flag_st_t        st_d, st_q;
    logic [DEPTH-1:0] sel;
    vcr_op_e         op;

    // one-hot write select, one comparator per word
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign sel[g] = we_i && (addr_i == AW'(g));
    end

    always_comb begin
        op   = vcr_decode(clr_i, we_i);
        st_d = st_q;
        unique case (op)
            VCR_WRITE:       st_d.vld = st_q.vld | sel;
            VCR_CLEAR:       st_d.vld = '0;
            VCR_CLEAR_WRITE: st_d.vld = sel;
            default:         st_d.vld = st_q.vld;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // flag of the word being read, before this edge's update
    assign hit_o = st_q.vld[addr_i];

    AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !we_i) |=> (st_q.vld == '0));                              // R2
    AST_WR_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> st_q.vld[$past(addr_i)]);                                    // R3
    AST_CLR_WR_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && we_i) |=> ($countones(st_q.vld) == 1));                     // R7

endmodule

// File: rtl/vcr_store.sv
module vcr_store #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o
);
    // plain array, no reset: contents may be stale, the flags hide them
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = mem[addr_i];
    end

    always_ff @(posedge clk_i) begin
        if (we_i) mem[addr_i] <= wdata_i;
        rd_q <= rd_d;
    end

    assign rdata_o = rd_q;

endmodule

// File: rtl/vcr_ram.sv
module vcr_ram #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o
);
    typedef struct packed {
        logic vld;
    } rd_st_t;

    rd_st_t           st_d, st_q;
    logic             hit;
    logic [WIDTH-1:0] raw;

    vcr_flag_array #(.DEPTH(DEPTH), .AW(AW)) u_flags (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_i),
        .we_i   (we_i),
        .addr_i (addr_i),
        .hit_o  (hit)
    );

    vcr_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
        .clk_i   (clk_i),
        .we_i    (we_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (raw)
    );

    // flag sampled at the same edge as the RAM word
    always_comb begin
        st_d.vld = hit;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rdata_o = st_q.vld ? raw : '0;

    AST_UNSET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit |=> (rdata_o == '0));                                            // R4
    AST_RAW_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(we_i) && (addr_i == $past(addr_i))) |=> (rdata_o == $past(wdata_i, 2))); // R10

endmodule

// File: tb/tb_vcr_ram.sv
`timescale 1ns/1ps
module tb_vcr_ram;
    localparam int DEPTH = 16;
    localparam int WIDTH = 8;
    localparam int AW    = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             we = 1'b0;
    logic [AW-1:0]    addr = '0;
    logic [WIDTH-1:0] wdata = '0;
    logic [WIDTH-1:0] rdata;

    int checks = 0;
    int errors = 0;

    logic [WIDTH-1:0] m_mem [DEPTH];
    logic [DEPTH-1:0] m_vld = '0;

    always #2.5 clk = ~clk;

    vcr_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
    );

    task automatic check(input string req, input logic [WIDTH-1:0] exp);
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%h expected=%h (t=%0t)", req, rdata, exp, $time);
        end
    endtask

    // one cycle: inputs set after a falling edge, result checked at the next falling edge
    task automatic cyc(input logic c, input logic w, input int a,
                       input logic [WIDTH-1:0] d, input string req);
        logic [WIDTH-1:0] exp;
        clr = c; we = w; addr = AW'(a); wdata = d;
        @(posedge clk);
        exp = m_vld[a] ? m_mem[a] : '0;    // read-before-update
        if (c) m_vld = '0;
        if (w) begin m_mem[a] = d; m_vld[a] = 1'b1; end
        @(negedge clk);
        check(req, exp);
    endtask

    function automatic logic [WIDTH-1:0] pat(input int a, input int k);
        return WIDTH'(a * 37 + k * 11 + 5);
    endfunction

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        // R1/R4: every address reads zero after reset
        for (int a = 0; a < DEPTH; a++) cyc(0, 0, a, '0, "R1");
        for (int a = 0; a < DEPTH; a++) cyc(0, 0, a, '0, "R4");
        // R3/R10: write each word, then read it back in the next cycle
        for (int a = 0; a < DEPTH; a++) begin
            cyc(0, 1, a, pat(a, 0), "R3");
            cyc(0, 0, a, '0, "R10");
        end
        // R5: full readout in reverse order
        for (int a = DEPTH - 1; a >= 0; a--) cyc(0, 0, a, '0, "R5");
        // R9: write over a valid word, same-cycle read shows old value
        cyc(0, 1, 6, 8'hA5, "R9");
        cyc(0, 0, 6, '0, "R10");
        // R9: clear while reading a valid word returns pre-clear value
        cyc(1, 0, 4, '0, "R9");
        // R2: everything reads zero
        for (int a = 0; a < DEPTH; a++) cyc(0, 0, a, '0, "R2");
        // R6: refill, then back-to-back clears and an immediate write
        for (int a = 0; a < DEPTH; a++) cyc(0, 1, a, pat(a, 1), "R6");
        cyc(1, 0, 0, '0, "R6");
        cyc(1, 0, 1, '0, "R6");
        cyc(0, 1, 2, 8'h3C, "R6");
        cyc(0, 0, 2, '0, "R6");
        for (int a = 0; a < DEPTH; a++) cyc(0, 0, a, '0, "R6");
        // R7: clear and write together, only the written word survives
        for (int a = 0; a < DEPTH; a++) cyc(0, 1, a, pat(a, 2), "R7");
        cyc(1, 1, 5, 8'h77, "R7");
        for (int a = 0; a < DEPTH; a++) cyc(0, 0, a, '0, "R7");
        // R8: rewriting a neighbour does not expose stale words
        cyc(1, 0, 0, '0, "R8");
        cyc(0, 1, 3, 8'hC3, "R8");
        for (int a = 0; a < DEPTH; a++) cyc(0, 0, a, '0, "R8");
        // R9: write to an unwritten word reads zero in its own cycle
        cyc(0, 1, 9, 8'h19, "R9");
        cyc(0, 0, 9, '0, "R9");
        // R11: sweep of clear/write mixes over all addresses
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < DEPTH; a++)
                cyc(((a + k) % 7) == 0, ((a * 3 + k) % 2) == 0, (a * 5 + k) % DEPTH,
                    pat(a, k + 3), "R11");
        // R1: reset mid-run clears flags
        rst_n = 1'b0;
        m_vld = '0;
        @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        for (int a = 0; a < DEPTH; a++) cyc(0, 0, a, '0, "R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule